// File: doc/BRIEF.md
# Dual-Mode Word Address Counter

This block keeps the internal word address of a byte-organised serial memory from one transaction to the next. The bus front end loads it from the two address bytes it receives. It then advances the counter after each data byte that moves in either direction. The value stays in the register after a transaction ends, so a read that sends no address starts from the byte after the last one accessed.

Writes and reads advance the counter in different ways. In write mode only the byte offset inside a 32-byte page counts, and it wraps back to the start of that same page. The page number does not change. In read mode the whole address counts, so a long read moves across page boundaries and wraps from the top of the array to address zero. The address width is a parameter: 12 bits for a 4096-byte array or 13 bits for an 8192-byte array. Load bits above that width are dropped.

Top module: `word_addr_ctr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the address output is zero.
- R2: A load places the low ADDR_W bits of the 16-bit load value on the address output in the next cycle. The load bits at and above ADDR_W have no effect.
- R3: When the load and step strobes are both high in the same cycle, the next address is the loaded value and the step is ignored.
- R4: A step with the mode bit low (write) adds one to address bits [4:0] and keeps bits [ADDR_W-1:5] unchanged.
- R5: A write-mode step from offset 31 of a page gives offset 0 of the same page.
- R6: A step with the mode bit high (read) adds one to the full address, and the carry moves into the page bits.
- R7: A read-mode step from the all-ones address gives address zero.
- R8: When neither strobe is high, the address holds its value for any number of cycles and under either mode setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the counter |
| load | input | 1 | Load strobe for the received address |
| load_addr | input | 16 | Address from the two received bytes; bits at and above ADDR_W are ignored |
| step | input | 1 | Advance strobe, one pulse per data byte |
| rd_mode | input | 1 | 1 = read wrap rule (whole array), 0 = write wrap rule (within the page) |
| addr | output | ADDR_W | Current word address |

## Verification
The hardest cases to reach are the two wrap points. The write wrap needs a step at offset 31 of a page. The read wrap needs a step at the all-ones address. Walking to either point one step at a time from reset is slow and tests little, so the stimulus loads an address just below each boundary and then steps across it in both modes. One case loads a value with all sixteen bits set, which checks the masking of the upper bits and the read wrap in the same sequence. Another steps in read mode from the last byte of a page, which is the one place where the two wrap rules give different results.

// File: rtl/word_addr_ctr.sv
module word_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int LOAD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_addr,
  input  logic              step,
  input  logic              rd_mode,
  output logic [ADDR_W-1:0] addr
);

  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;
  logic [ADDR_W-1:0] rd_next;
  logic [ADDR_W-1:0] wr_next;
  logic [PAGE_W-1:0] off_next;

  assign off_next = cnt_q[PAGE_W-1:0] + 1'b1;
  assign wr_next  = {cnt_q[ADDR_W-1:PAGE_W], off_next};
  assign rd_next  = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_addr[ADDR_W-1:0];
    else if (step) cnt_d = rd_mode ? rd_next : wr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign addr = cnt_q;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (addr == '0 || !rst_n));

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_addr[ADDR_W-1:0]));

  p_load_beats_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && step) |=> addr == $past(load_addr[ADDR_W-1:0]));

  p_page_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !rd_mode) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !rd_mode && (&addr[PAGE_W-1:0])) |=> addr[PAGE_W-1:0] == '0);

  p_full_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && rd_mode && !(&addr)) |=> addr == $past(addr) + 1'b1);

  p_top_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && rd_mode && (&addr)) |=> addr == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));

  initial begin
    assert (ROW_W > 0);
  end

endmodule

// File: tb/sim_word_addr_ctr.sv
module sim_word_addr_ctr;
  localparam int AW    = 13;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [15:0]   load_addr = '0;
  logic          step = 1'b0;
  logic          rd_mode = 1'b0;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  word_addr_ctr #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .step(step), .rd_mode(rd_mode), .addr(addr)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input int la, input bit st, input bit rd, input string tag);
    @(negedge clk);
    load = ld; load_addr = la[15:0]; step = st; rd_mode = rd;
    if (ld) model = la & (DEPTH - 1);
    else if (st && rd) model = (model + 1) % DEPTH;
    else if (st) model = (model & ~31) | ((model + 1) & 31);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(int'(addr), exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #9; check(int'(addr), 0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check(int'(addr), 0, "R1 after release");

    drive(1, 'h0123, 0, 0, "R2 load");
    drive(1, 'hE456, 0, 1, "R2 upper bits masked");
    drive(1, 'h0040, 1, 1, "R3 load beats read step");
    drive(1, 'h0050, 1, 0, "R3 load beats write step");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, "R4 write step");
    drive(1, 'h0A3D, 0, 0, "R5 load near page end");
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, "R5 write wrap in page");
    drive(1, 'h003E, 0, 0, "R6 load near page end");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 1, "R6 read crosses page");
    drive(1, 'hFFFF, 0, 1, "R2 all ones masked");
    drive(0, 0, 1, 1, "R7 read wrap to zero");
    drive(0, 0, 1, 1, "R7 read after wrap");
    drive(1, 'h1FFF, 0, 0, "R7 load top");
    drive(0, 0, 1, 0, "R5 write wrap top page");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, i % 2, "R8 hold idle");
    drive(0, 0, 1, 1, "R8 resume after hold");
    drive(0, 0, 0, 0, "R8 hold final");
    @(negedge clk); load = 0; step = 0;
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule